// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide register port. Addresses 0 to 2 are the data ports of counters 0 to 2. Address 3 takes control words. A control word picks one counter and sets three things for it: how its bytes are transferred, whether it runs as a one-shot terminal-count timer or as a periodic rate generator, and the counting mode. The same port also accepts two capture commands. One freezes a single counter's value. The other freezes any subset of counters at once.

Counting advances on clock edges where the shared timer enable `cnt_en` is high and the counter's own `gate` input is high. Software typically does one of two things. It arms a one-shot and polls the matching `cnt_out` bit until it rises. Or it programs a rate generator with reload 0, which gives the longest period of 65536 counts, and uses its output pulses as a periodic tick. Elapsed time is read back by freezing the count and then reading two bytes, low byte first.

Top module: `prog_timer`

## Requirements
- R1: After reset every `cnt_out` bit is 1, every counter holds 0 and does not count until a reload value has been loaded, and every counter uses low-then-high word access.
- R2: A write to address 3 with bits 7:6 = channel (0..2) and bits 5:4 nonzero sets that channel's access type from bits 5:4. The channel's output is 0 from the next edge in one-shot mode and 1 in rate mode. Counting stops until a new reload value is complete.
- R3: With access type 3, the first data write supplies the low byte and the second supplies the high byte. The counter takes the 16-bit value on the edge of the second write.
- R4: In one-shot mode, N counting edges after the load the output goes to 1. It then stays at 1 until a control word for that channel is written or a data byte is written to it. The count wraps from 0 to 0xFFFF.
- R5: In rate mode with reload N ≥ 2, the output is 1 for N−1 counting edges, then 0 for exactly one counting edge while the count is 1. The counter then reloads N and the output returns to 1, so the period is N.
- R6: A reload value of 0 counts as 65536 in both modes.
- R7: A counter whose `gate` bit is 0 holds its count.
- R8: With access type 1, a data write loads {0x00, byte} and a read returns the low byte. With access type 2, a data write loads {byte, 0x00} and a read returns the high byte.
- R9: A control word with bits 5:4 = 0 freezes that channel's count in a read latch. Reads return the frozen value until the latch has been fully read (both bytes with access type 3). The counter keeps running meanwhile. Reads after that return the live count.
- R10: A control word with bits 7:6 = 3 and bit 5 = 0 freezes every counter whose select bit is set (bit 1 for counter 0, bit 2 for counter 1, bit 3 for counter 2). With bit 5 = 1 the command freezes nothing.
- R11: Mode field bits 3:1 equal to 2 or 6 select rate mode. Every other value selects one-shot mode. Bit 0 has no effect, and counting is always binary.
- R12: A freeze command for a channel whose latch is still unread is ignored, so the first frozen value is kept.
- R13: No counter changes on an edge where `cnt_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timer clock enable shared by all counters |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | 0..2 counter data ports, 3 control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| gate | input | NCH | Per-counter count permit |
| cnt_out | output | NCH | Per-counter output |

## Verification
Control words and loads take effect on the edge that samples the write, so `cnt_out` and the count show the change from the next falling edge. A one-shot output rises on the N-th counting edge after the loading edge. A rate generator's output falls on edge N−1 and rises on edge N. Read data is combinational and is sampled one time step after `rd_en` is driven within the same cycle. The bench drives every input on a falling edge and samples on falling edges. It counts falling edges from the load until the output changes and compares that count with N, N−1 or 1. Freeze checks run with `cnt_en` low, so the expected count is fixed arithmetic.

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [1:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] gate,
  output logic [NCH-1:0] cnt_out
);
  localparam int BW = CW / 2;

  logic [NCH-1:0][CW-1:0] cnt_q, rld_q, lat_q, ld_val;
  logic [NCH-1:0][BW-1:0] lo_q;
  logic [NCH-1:0][1:0]    acc_q;
  logic [NCH-1:0] rate_q, armed_q, latched_q, wtog_q, rtog_q;
  logic [NCH-1:0] ctl_hit, cap, dwr, drd, dec, ld_fire, rd_done;

  wire ctl_wr = wr_en && (addr == 2'd3);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ctl_hit[i] = ctl_wr && (wdata[7:6] == 2'(i));
      cap[i]     = !latched_q[i] &&
                   ((ctl_hit[i] && wdata[5:4] == 2'd0) ||
                    (ctl_wr && wdata[7:6] == 2'd3 && !wdata[5] && wdata[i+1]));
      dwr[i]     = wr_en && (addr == 2'(i));
      drd[i]     = rd_en && (addr == 2'(i));
      dec[i]     = armed_q[i] && gate[i] && cnt_en;
      ld_fire[i] = dwr[i] && (acc_q[i] != 2'd3 || wtog_q[i]);
      rd_done[i] = drd[i] && (acc_q[i] != 2'd3 || rtog_q[i]);
      case (acc_q[i])
        2'd1:    ld_val[i] = {{BW{1'b0}}, wdata};
        2'd2:    ld_val[i] = {wdata, {BW{1'b0}}};
        default: ld_val[i] = {wdata, lo_q[i]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      lat_q     <= '0;
      lo_q      <= '0;
      acc_q     <= {NCH{2'd3}};
      rate_q    <= '0;
      armed_q   <= '0;
      latched_q <= '0;
      wtog_q    <= '0;
      rtog_q    <= '0;
      cnt_out   <= '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (drd[i] && acc_q[i] == 2'd3) rtog_q[i] <= !rtog_q[i];
        if (rd_done[i]) latched_q[i] <= 1'b0;
        if (cap[i]) begin
          lat_q[i]     <= cnt_q[i];
          latched_q[i] <= 1'b1;
        end
        if (ctl_hit[i] && wdata[5:4] != 2'd0) begin
          acc_q[i]     <= wdata[5:4];
          rate_q[i]    <= (wdata[2:1] == 2'b10);
          cnt_out[i]   <= (wdata[2:1] == 2'b10);
          armed_q[i]   <= 1'b0;
          wtog_q[i]    <= 1'b0;
          rtog_q[i]    <= 1'b0;
          latched_q[i] <= 1'b0;
        end else if (ld_fire[i]) begin
          cnt_q[i]   <= ld_val[i];
          rld_q[i]   <= ld_val[i];
          armed_q[i] <= 1'b1;
          wtog_q[i]  <= 1'b0;
          cnt_out[i] <= rate_q[i];
        end else if (dwr[i]) begin
          lo_q[i]    <= wdata;
          wtog_q[i]  <= 1'b1;
          armed_q[i] <= 1'b0;
          if (!rate_q[i]) cnt_out[i] <= 1'b0;
        end else if (dec[i]) begin
          if (rate_q[i] && cnt_q[i] == CW'(1)) begin
            cnt_q[i]   <= rld_q[i];
            cnt_out[i] <= 1'b1;
          end else begin
            cnt_q[i] <= cnt_q[i] - CW'(1);
            if (rate_q[i] && cnt_q[i] == CW'(2)) cnt_out[i] <= 1'b0;
            if (!rate_q[i] && cnt_q[i] == CW'(1)) cnt_out[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    logic [CW-1:0] src;
    rdata = '0;
    src   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) begin
        src = latched_q[i] ? lat_q[i] : cnt_q[i];
        if (acc_q[i] == 2'd2 || (acc_q[i] == 2'd3 && rtog_q[i]))
          rdata = src[CW-1:BW];
        else
          rdata = src[BW-1:0];
      end
    end
  end
endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cnt_en,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [NCH-1:0]         gate,
  input logic [NCH-1:0]         out_q,
  input logic [NCH-1:0]         rate_q,
  input logic [NCH-1:0]         latched_q,
  input logic [NCH-1:0][CW-1:0] cnt_q,
  input logic [NCH-1:0][CW-1:0] lat_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(gate[i] && cnt_en)) |=> $stable(cnt_q[i]));

    assert_tc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rate_q[i] && out_q[i] && !wr_en) |=> out_q[i]);

    assert_low_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q[i] && $fell(out_q[i])) |-> (cnt_q[i] == CW'(1)));

    assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q[i] && !out_q[i] && gate[i] && cnt_en && !wr_en) |=> out_q[i]);

    assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_q[i] && !rd_en && !wr_en) |=> (latched_q[i] && $stable(lat_q[i])));
  end
endmodule

bind prog_timer prog_timer_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
  .gate(gate), .out_q(cnt_out), .rate_q(rate_q), .latched_q(latched_q),
  .cnt_q(cnt_q), .lat_q(lat_q)
);

// File: tb/prog_timer_tb.sv
module prog_timer_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, cnt_en, wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] gate, cnt_out;

  int checks = 0, errors = 0, cyc = 0;

  prog_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gate(gate), .cnt_out(cnt_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input int ch, input int acc, input int mode, input bit bcd);
    return {2'(ch), 2'(acc), 3'(mode), bcd};
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_en = 1'b1; addr = 2'(a);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_word(input int a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {16'h0, hi, lo};
  endtask

  task automatic load(input int ch, input int val);
    wr(ch, 8'(val));
    wr(ch, 8'(val >> 8));
  endtask

  task automatic wait_out(input int ch, input bit lvl, input int limit, output int k);
    k = 0;
    while (cnt_out[ch] != lvl && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, v;
    logic [7:0] b;
    rst_n = 1'b0; cnt_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; gate = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(cnt_out == 3'b111, "R1 outputs after reset", cnt_out, 7);
    rd_word(2, v);
    check(v == 0, "R1 count after reset", v, 0);

    for (int n = 1; n <= 20; n++) begin
      int md;
      md = (n % 2 == 1) ? 0 : ((n % 8 == 2) ? 1 : (n % 8 == 4) ? 3 : (n % 8 == 6) ? 4 : 5);
      wr(3, ctl(0, 3, md, (n % 3 == 0)));
      check(cnt_out[0] == 1'b0, "R2 one-shot output low", cnt_out[0], 0);
      load(0, n);
      wait_out(0, 1'b1, 100, k);
      check(k == n, "R4 R11 one-shot edges to terminal count", k, n);
      repeat (n + 3) @(negedge clk);
      check(cnt_out[0] == 1'b1, "R4 output stays high", cnt_out[0], 1);
    end

    for (int n = 2; n <= 20; n++) begin
      wr(3, ctl(1, 3, (n % 2 == 1) ? 6 : 2, 1'b0));
      check(cnt_out[1] == 1'b1, "R2 rate output high", cnt_out[1], 1);
      load(1, n);
      wait_out(1, 1'b0, 100, k);
      check(k == n - 1, "R5 R3 edges to low", k, n - 1);
      wait_out(1, 1'b1, 100, k);
      check(k == 1, "R5 low width", k, 1);
      wait_out(1, 1'b0, 100, k);
      check(k == n - 1, "R5 R11 reloaded high time", k, n - 1);
    end

    gate[2] = 1'b0;
    wr(3, ctl(2, 3, 0, 1'b0));
    load(2, 8);
    repeat (5) @(negedge clk);
    check(cnt_out[2] == 1'b0, "R7 gated output low", cnt_out[2], 0);
    wr(3, ctl(2, 0, 0, 1'b0));
    rd_word(2, v);
    check(v == 8, "R7 gated count held", v, 8);
    gate[2] = 1'b1;
    wait_out(2, 1'b1, 100, k);
    check(k == 8, "R7 count after gate", k, 8);

    wr(3, ctl(0, 3, 2, 1'b0));
    load(0, 0);
    wait_out(0, 1'b0, 70000, k);
    check(k == 65535, "R6 rate zero reload low after", k, 65535);
    wait_out(0, 1'b1, 10, k);
    check(k == 1, "R6 rate zero reload pulse", k, 1);

    cnt_en = 1'b0;
    wr(3, ctl(1, 3, 0, 1'b0));
    load(1, 0);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    wr(3, ctl(1, 0, 0, 1'b0));
    rd_word(1, v);
    check(v == 16'hFFFD, "R6 zero reload wraps", v, 16'hFFFD);
    check(cnt_out[1] == 1'b0, "R6 one-shot not yet done", cnt_out[1], 0);

    wr(3, ctl(1, 1, 0, 1'b0));
    wr(1, 8'h37);
    rd(1, b);
    check(b == 8'h37, "R8 low-only read", b, 8'h37);
    wr(3, ctl(1, 2, 0, 1'b0));
    wr(1, 8'h12);
    rd(1, b);
    check(b == 8'h12, "R8 high-only read", b, 8'h12);
    wr(3, ctl(1, 3, 0, 1'b0));
    rd_word(1, v);
    check(v == 16'h1200, "R8 high-only zero low byte", v, 16'h1200);

    wr(3, ctl(0, 3, 0, 1'b0));
    load(0, 1000);
    cnt_en = 1'b1;
    repeat (10) @(negedge clk);
    cnt_en = 1'b0;
    wr(3, ctl(0, 0, 0, 1'b0));
    cnt_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_en = 1'b0;
    wr(3, ctl(0, 0, 0, 1'b0));
    rd_word(0, v);
    check(v == 990, "R9 R12 frozen value", v, 990);
    rd_word(0, v);
    check(v == 983, "R9 R13 live count after latch read", v, 983);

    wr(3, ctl(1, 3, 0, 1'b0));
    load(1, 16'h1234);
    wr(3, ctl(2, 3, 0, 1'b0));
    load(2, 16'h0ABC);
    wr(3, 8'hDC);
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    cnt_en = 1'b0;
    rd_word(1, v);
    check(v == 16'h1234, "R10 counter 1 frozen", v, 16'h1234);
    rd_word(2, v);
    check(v == 16'h0ABC, "R10 counter 2 frozen", v, 16'h0ABC);
    rd_word(0, v);
    check(v == 978, "R10 counter 0 not selected", v, 978);
    wr(3, 8'hFE);
    cnt_en = 1'b1;
    repeat (2) @(negedge clk);
    cnt_en = 1'b0;
    rd_word(1, v);
    check(v == 16'h1234 - 7, "R10 bit5 set freezes nothing", v, 16'h1234 - 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule